// File: doc/BRIEF.md
# Receive Descriptor-Chain Writeback Engine

This block moves received frames into memory by following a linked chain of eight-word receive descriptors. When a frame starts arriving, the engine reads the current descriptor and checks whether software has handed it over. If it has, the engine packs the frame's bytes into the descriptor's buffer. It then writes back the stored length and a status word that returns ownership to software, and moves on to the descriptor named by the next pointer. If software still holds the descriptor, the frame is swallowed and counted, and the descriptor is left untouched.

Software programs a descriptor pointer, then sets the pointer-valid bit and the go bit. The engine stops when it finishes the descriptor flagged as last in the chain. At that point it raises a sticky end-of-queue flag and clears the valid bit, and it refuses further bytes until software arms a pointer again. Memory is reached through a word-addressed master port with a fixed one-cycle read latency. Frames arrive as a byte stream with a ready/valid handshake, a last-byte marker and an error flag on the last byte.

Top module: `rxd_engine`

## Requirements
- R1: After reset every register reads 0, `in_ready` is low and no memory request is issued.
- R2: Register map (word index on `reg_addr`): 0 = control with go in bit 0, 1 = descriptor byte pointer, 2 = bit 31 pointer-valid, 3 = end-of-queue flag in bit 0, 4 = dropped-frame count. Bytes are accepted only while go and valid are both 1; otherwise `in_ready` stays low.
- R3: For each frame the engine reads the descriptor at the pointer. Word 5 bit 15 = 1 means the engine owns it, and bits 31:16 of word 5 hold the buffer size in bytes.
- R4: Stored bytes go to consecutive words from the byte address in word 0, byte i in lane i mod 4 (bits 8*(i mod 4)+7 down to 8*(i mod 4)). Unused upper lanes of the final word are written as 0.
- R5: After the last byte, word 4 of the descriptor is written with the stored byte count in bits 15:0 and zeros above.
- R6: Word 5 is then written with the size kept in bits 31:16, bit 15 = 0, bit 0 = 1, bit 1 = 1, and bit 12 = the error flag on the last byte. Bit 8 (bad frame) is set when any of bits 4, 11 or 12 is set.
- R7: A frame that stores fewer than MIN_BYTES bytes sets bit 4 of the status word.
- R8: Bytes beyond the buffer size are accepted but not stored. The count equals the size, and bits 11 and 8 are set.
- R9: A frame arriving on a descriptor whose owner bit is 0 is consumed without touching memory. The dropped count rises by 1, the pointer stays, and the next completed status word carries bit 9 (overrun).
- R10: A descriptor whose word 3 has bit 31 clear advances the pointer to word 2. If bit 31 is set, after writeback the end-of-queue flag becomes 1, the valid bit clears, and `in_ready` stays low.
- R11: The end-of-queue flag is cleared only by writing 1 to bit 0 of register 3; writing 0 leaves it. Writing a new pointer and setting valid restarts the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| in_valid | input | 1 | Frame byte present |
| in_ready | output | 1 | Engine takes the byte this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_err | input | 1 | Frame failed its check (valid with last) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |

## Verification
The bench builds the engine with a 10-bit word address and MIN_BYTES of 8. A 1024-word memory therefore holds a five-descriptor chain and its buffers. Frames of a handful of bytes can then cover the short-frame flag, a frame just over the threshold, and a 10-byte buffer that truncates a 17-byte frame mid-word. The small address space also lets the reference image of the whole memory be checked against every write the engine issues.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;

    // descriptor word offsets
    localparam int OFF_BUF = 0;
    localparam int OFF_NXL = 2;
    localparam int OFF_NXH = 3;
    localparam int OFF_CNT = 4;
    localparam int OFF_CS  = 5;

    // bit positions inside descriptor words and registers
    localparam int B_EOF   = 0;
    localparam int B_SOF   = 1;
    localparam int B_SHORT = 4;
    localparam int B_BAD   = 8;
    localparam int B_OVR   = 9;
    localparam int B_MAXL  = 11;
    localparam int B_CRC   = 12;
    localparam int B_OWN   = 15;
    localparam int B_LAST  = 31;
    localparam int B_VALID = 31;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_PTRL = 3'd1;
    localparam logic [2:0] RA_PTRH = 3'd2;
    localparam logic [2:0] RA_EOQ  = 3'd3;
    localparam logic [2:0] RA_DROP = 3'd4;

    localparam int FETCH_STEPS = 4;

    typedef enum logic [2:0] {
        W_IDLE, W_FETCH, W_RECV, W_DROP, W_WCNT, W_WCS
    } walk_e;

    typedef struct packed {
        logic [31:0] nxt_addr;
        logic [15:0] size;
        logic        own;
        logic        last;
    } desc_t;

    typedef struct packed {
        logic short_f;
        logic trunc;
        logic crc;
        logic ovr;
    } fstat_t;

    // order in which descriptor words are read: ownership first
    function automatic logic [2:0] fetch_off(input logic [2:0] step);
        case (step[1:0])
            2'd0:    return 3'(OFF_CS);
            2'd1:    return 3'(OFF_BUF);
            2'd2:    return 3'(OFF_NXL);
            default: return 3'(OFF_NXH);
        endcase
    endfunction

    function automatic logic [31:0] status_word(input logic [15:0] size,
                                                input fstat_t s);
        logic [31:0] w;
        w          = {size, 16'h0000};
        w[B_EOF]   = 1'b1;
        w[B_SOF]   = 1'b1;
        w[B_SHORT] = s.short_f;
        w[B_MAXL]  = s.trunc;
        w[B_CRC]   = s.crc;
        w[B_OVR]   = s.ovr;
        w[B_BAD]   = s.short_f | s.trunc | s.crc;
        return w;
    endfunction

endpackage

// File: rtl/rxd_regs.sv
`timescale 1ns/1ps
module rxd_regs
    import rxd_pkg::*;
#(
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              adv,
    input  logic              adv_last,
    input  logic [31:0]       adv_next,
    input  logic              drop,
    output logic              go,
    output logic              valid,
    output logic              eoq,
    output logic [31:0]       ptr,
    output logic [DROP_W-1:0] drops,
    output logic [31:0]       rdata
);

    logic wr_ctrl, wr_ptrl, wr_ptrh, wr_eoq;
    assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign wr_ptrl = reg_we && (reg_addr == RA_PTRL);
    assign wr_ptrh = reg_we && (reg_addr == RA_PTRH);
    assign wr_eoq  = reg_we && (reg_addr == RA_EOQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            go    <= 1'b0;
            valid <= 1'b0;
            eoq   <= 1'b0;
            ptr   <= '0;
            drops <= '0;
        end else begin
            if (wr_ctrl) go <= reg_wdata[0];

            if (wr_ptrl)                ptr <= reg_wdata;
            else if (adv && !adv_last)  ptr <= adv_next;

            if (wr_ptrh)                valid <= reg_wdata[B_VALID];
            else if (adv && adv_last)   valid <= 1'b0;

            if (adv && adv_last)               eoq <= 1'b1;
            else if (wr_eoq && reg_wdata[0])   eoq <= 1'b0;

            if (drop) drops <= drops + 1'b1;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: rdata = {31'd0, go};
            RA_PTRL: rdata = ptr;
            RA_PTRH: rdata = {valid, 31'd0};
            RA_EOQ:  rdata = {31'd0, eoq};
            RA_DROP: rdata = 32'(drops);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/rxd_pack.sv
`timescale 1ns/1ps
module rxd_pack #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fire,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_err,
    input  logic [ADDR_W-1:0] buf_w,
    input  logic [15:0]       size,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [31:0]       wdata,
    output logic [15:0]       cnt,
    output logic              trunc,
    output logic              crc
);

    localparam int LANES = 4;

    logic [31:0] acc;
    logic [31:0] merged;
    logic        store;
    logic        word_end;

    assign store    = fire && (cnt < size);
    assign word_end = (cnt[1:0] == 2'(LANES - 1)) || in_last || ((cnt + 16'd1) == size);
    assign we       = store && word_end;
    assign addr     = buf_w + ADDR_W'(cnt[15:2]);
    assign wdata    = merged;

    // place the incoming byte into its lane of the word being assembled
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            always_comb begin
                if (cnt[1:0] == 2'(g)) merged[8*g +: 8] = in_data;
                else                   merged[8*g +: 8] = acc[8*g +: 8];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt   <= '0;
            acc   <= '0;
            trunc <= 1'b0;
            crc   <= 1'b0;
        end else if (fire) begin
            if (store) begin
                cnt <= cnt + 16'd1;
                acc <= word_end ? 32'd0 : merged;
            end else begin
                trunc <= 1'b1;
            end
            if (in_last) crc <= in_err;
        end
    end

endmodule

// File: rtl/rxd_walker.sv
`timescale 1ns/1ps
module rxd_walker
    import rxd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MIN_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              armed,
    input  logic [ADDR_W-1:0] ptr_w,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              pk_we,
    input  logic [ADDR_W-1:0] pk_addr,
    input  logic [31:0]       pk_wdata,
    input  logic [15:0]       pk_cnt,
    input  logic              pk_trunc,
    input  logic              pk_crc,
    output logic              pk_start,
    output logic              pk_fire,
    output logic [ADDR_W-1:0] buf_w,
    output logic [15:0]       size,
    output logic              adv,
    output logic              adv_last,
    output logic [31:0]       adv_next,
    output logic              drop
);

    walk_e             st;
    logic [2:0]        step;
    logic [2:0]        prev;
    desc_t             d;
    logic              pend_ovr;
    logic [ADDR_W-1:0] dbase;
    logic              fire;
    fstat_t            fs;

    assign in_ready = (st == W_RECV) || (st == W_DROP);
    assign fire     = in_valid && in_ready;
    assign pk_start = (st == W_IDLE) && armed && in_valid;
    assign pk_fire  = fire && (st == W_RECV);
    assign drop     = fire && in_last && (st == W_DROP);
    assign adv      = (st == W_WCS);
    assign adv_last = d.last;
    assign adv_next = d.nxt_addr;
    assign size     = d.size;
    assign prev     = step - 3'd1;

    assign fs.short_f = pk_cnt < 16'(MIN_BYTES);
    assign fs.trunc   = pk_trunc;
    assign fs.crc     = pk_crc;
    assign fs.ovr     = pend_ovr;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dbase;
        mem_wdata = '0;
        case (st)
            W_FETCH: begin
                mem_req  = (step < 3'(FETCH_STEPS));
                mem_addr = dbase + ADDR_W'(fetch_off(step));
            end
            W_RECV: begin
                mem_req   = pk_we;
                mem_we    = pk_we;
                mem_addr  = pk_addr;
                mem_wdata = pk_wdata;
            end
            W_WCNT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dbase + ADDR_W'(OFF_CNT);
                mem_wdata = {16'h0000, pk_cnt};
            end
            W_WCS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dbase + ADDR_W'(OFF_CS);
                mem_wdata = status_word(d.size, fs);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= W_IDLE;
            step     <= '0;
            d        <= '0;
            buf_w    <= '0;
            pend_ovr <= 1'b0;
            dbase    <= '0;
        end else begin
            case (st)
                W_IDLE: if (pk_start) begin
                    st    <= W_FETCH;
                    step  <= '0;
                    dbase <= ptr_w;
                end
                W_FETCH: begin
                    step <= step + 3'd1;
                    if (step != 3'd0) begin
                        case (fetch_off(prev))
                            3'(OFF_CS): begin
                                d.own  <= mem_rdata[B_OWN];
                                d.size <= mem_rdata[31:16];
                            end
                            3'(OFF_BUF): buf_w      <= mem_rdata[ADDR_W+1:2];
                            3'(OFF_NXL): d.nxt_addr <= mem_rdata;
                            default:     d.last     <= mem_rdata[B_LAST];
                        endcase
                    end
                    if (step == 3'(FETCH_STEPS)) st <= d.own ? W_RECV : W_DROP;
                end
                W_RECV: if (fire && in_last) st <= W_WCNT;
                W_DROP: if (fire && in_last) begin
                    st       <= W_IDLE;
                    pend_ovr <= 1'b1;
                end
                W_WCNT: st <= W_WCS;
                W_WCS: begin
                    st       <= W_IDLE;
                    pend_ovr <= 1'b0;
                end
                default: st <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxd_engine.sv
`timescale 1ns/1ps
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MIN_BYTES = 64,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);

    logic              go_w, valid_w, eoq_w;
    logic [31:0]       ptr_w;
    logic [DROP_W-1:0] drops_w;
    logic              adv_w, adv_last_w, drop_w;
    logic [31:0]       adv_next_w;
    logic              pk_start_w, pk_fire_w, pk_we_w, pk_trunc_w, pk_crc_w;
    logic [ADDR_W-1:0] pk_addr_w, buf_w_w;
    logic [31:0]       pk_wdata_w;
    logic [15:0]       pk_cnt_w, size_w;

    rxd_regs #(.DROP_W(DROP_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .adv      (adv_w),
        .adv_last (adv_last_w),
        .adv_next (adv_next_w),
        .drop     (drop_w),
        .go       (go_w),
        .valid    (valid_w),
        .eoq      (eoq_w),
        .ptr      (ptr_w),
        .drops    (drops_w),
        .rdata    (reg_rdata)
    );

    rxd_walker #(.ADDR_W(ADDR_W), .MIN_BYTES(MIN_BYTES)) walk_i (
        .clk      (clk),
        .rst      (rst),
        .armed    (go_w && valid_w),
        .ptr_w    (ptr_w[ADDR_W+1:2]),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_ready (in_ready),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .pk_we    (pk_we_w),
        .pk_addr  (pk_addr_w),
        .pk_wdata (pk_wdata_w),
        .pk_cnt   (pk_cnt_w),
        .pk_trunc (pk_trunc_w),
        .pk_crc   (pk_crc_w),
        .pk_start (pk_start_w),
        .pk_fire  (pk_fire_w),
        .buf_w    (buf_w_w),
        .size     (size_w),
        .adv      (adv_w),
        .adv_last (adv_last_w),
        .adv_next (adv_next_w),
        .drop     (drop_w)
    );

    rxd_pack #(.ADDR_W(ADDR_W)) pack_i (
        .clk    (clk),
        .rst    (rst),
        .start  (pk_start_w),
        .fire   (pk_fire_w),
        .in_data(in_data),
        .in_last(in_last),
        .in_err (in_err),
        .buf_w  (buf_w_w),
        .size   (size_w),
        .we     (pk_we_w),
        .addr   (pk_addr_w),
        .wdata  (pk_wdata_w),
        .cnt    (pk_cnt_w),
        .trunc  (pk_trunc_w),
        .crc    (pk_crc_w)
    );

endmodule

// File: rtl/rxd_engine_chk.sv
`timescale 1ns/1ps
module rxd_engine_chk
    import rxd_pkg::*;
#(
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic              mem_req,
    input logic              mem_we,
    input logic              eoq,
    input logic              valid,
    input logic [DROP_W-1:0] drops
);

    // R3: descriptor reads never overlap byte acceptance
    a_r3_no_fetch_while_taking: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !(mem_req && !mem_we));

    // R9: the dropped count moves only after a consumed last byte
    a_r9_drop_on_last: assert property (@(posedge clk) disable iff (rst)
        (drops != $past(drops)) |-> $past(in_valid && in_ready && in_last));

    // R10: end of queue is raised right after a status writeback
    a_r10_eoq_after_wb: assert property (@(posedge clk) disable iff (rst)
        $rose(eoq) |-> $past(mem_req && mem_we));

    // R10: valid only falls with end of queue or a software write
    a_r10_valid_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(valid) |-> (eoq || $past(reg_we && reg_addr == RA_PTRH)));

    // R11: end of queue holds until a write of 1 to its bit
    a_r11_eoq_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(eoq) && !$past(reg_we && reg_addr == RA_EOQ && reg_wdata[0])) |-> eoq);

endmodule

bind rxd_engine rxd_engine_chk #(.DROP_W(DROP_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_last  (in_last),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .eoq      (eoq_w),
    .valid    (valid_w),
    .drops    (drops_w)
);

// File: tb/rxd_engine_tb_top.sv
`timescale 1ns/1ps
module rxd_engine_tb_top;
    import rxd_pkg::*;

    localparam int AW   = 10;
    localparam int MINB = 8;
    localparam int NW   = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic          in_err = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;

    rxd_engine #(.ADDR_W(AW), .MIN_BYTES(MINB), .DROP_W(16)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .in_err(in_err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem     [0:NW-1];
    logic [31:0] exp_mem [0:NW-1];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    int total = 0;
    int bad   = 0;

    // reference model state
    int m_ptr   = 0;
    bit m_pend  = 0;
    int m_drops = 0;

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every write the engine issues must match the model's memory image
    always @(negedge clk) begin
        if (!rst && mem_req && mem_we)
            chk_eq("R4 R5 R6 write image", mem_wdata, exp_mem[mem_addr]);
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [7:0] bv(input int seed, input int i);
        return 8'(seed + i * 7 + (i >> 2) * 13);
    endfunction

    task automatic rw(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rr(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic put_desc(input int di, input int bufa, input int size,
                            input bit own, input int nxt, input bit last);
        logic [31:0] w [0:7];
        w[0] = 32'(bufa);
        w[1] = 32'h0;
        w[2] = 32'(nxt);
        w[3] = {last, 31'd0};
        w[4] = 32'h0;
        w[5] = {16'(size), own, 15'd0};
        w[6] = 32'hA5A5_0006;
        w[7] = 32'hA5A5_0007;
        for (int k = 0; k < 8; k++) begin
            mem[di * 8 + k]     = w[k];
            exp_mem[di * 8 + k] = w[k];
        end
    endtask

    task automatic send(input int n, input int seed, input bit err, input string tag);
        int          wb;
        bit          own;
        int          size;
        int          bufw;
        int          stored;
        logic [31:0] cs;
        logic [31:0] word;
        logic [31:0] saved [0:7];
        bit          sh, tr;
        wb   = m_ptr / 4;
        own  = exp_mem[wb + OFF_CS][B_OWN];
        size = int'(exp_mem[wb + OFF_CS][31:16]);
        bufw = int'(exp_mem[wb + OFF_BUF][AW+1:2]);
        for (int k = 0; k < 8; k++) saved[k] = exp_mem[wb + k];
        stored = 0;
        if (own) begin
            stored = (n < size) ? n : size;
            for (int k = 0; k < (stored + 3) / 4; k++) begin
                word = 32'h0;
                for (int l = 0; l < 4; l++)
                    if (k * 4 + l < stored) word[8*l +: 8] = bv(seed, k * 4 + l);
                exp_mem[bufw + k] = word;
            end
            sh = stored < MINB;
            tr = n > size;
            cs = {16'(size), 16'h0003};
            cs[B_SHORT] = sh;
            cs[B_MAXL]  = tr;
            cs[B_CRC]   = err;
            cs[B_BAD]   = sh | tr | err;
            cs[B_OVR]   = m_pend;
            m_pend = 0;
            exp_mem[wb + OFF_CNT] = 32'(stored);
            exp_mem[wb + OFF_CS]  = cs;
            if (!exp_mem[wb + OFF_NXH][B_LAST]) m_ptr = int'(exp_mem[wb + OFF_NXL]);
        end else begin
            m_drops++;
            m_pend = 1;
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = bv(seed, i);
            in_last  = (i == n - 1);
            in_err   = err && (i == n - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_err   = 1'b0;
        repeat (8) @(negedge clk);
        if (own) begin
            chk_eq({tag, " count word"}, mem[wb + OFF_CNT], exp_mem[wb + OFF_CNT]);
            chk_eq({tag, " status word"}, mem[wb + OFF_CS], exp_mem[wb + OFF_CS]);
            for (int k = 0; k < (stored + 3) / 4; k++)
                chk_eq({tag, " buffer word"}, mem[bufw + k], exp_mem[bufw + k]);
        end else begin
            for (int k = 0; k < 8; k++)
                chk_eq({tag, " R9 descriptor untouched"}, mem[wb + k], saved[k]);
        end
    endtask

    task automatic stall_check(input string tag);
        bit seen;
        seen = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h5A;
        in_last  = 1'b1;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (in_ready || mem_req) seen = 1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk_eq(tag, 32'(seen), 32'd0);
    endtask

    initial begin
        logic [31:0] r;
        for (int k = 0; k < NW; k++) begin
            mem[k]     = 32'hDEAD_0000 | 32'(k);
            exp_mem[k] = 32'hDEAD_0000 | 32'(k);
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rr(3'(a), r);
            chk_eq("R1 register after reset", r, 32'h0);
        end
        chk_eq("R1 in_ready after reset", 32'(in_ready), 32'd0);
        chk_eq("R1 mem_req after reset", 32'(mem_req), 32'd0);

        // chain of five descriptors; buffers from byte 0x400
        put_desc(0, 'h400, 64, 1, 'h20, 0);
        put_desc(1, 'h480, 64, 1, 'h40, 0);
        put_desc(2, 'h500, 64, 1, 'h60, 0);
        put_desc(3, 'h580, 10, 1, 'h80, 0);
        put_desc(4, 'h600, 64, 0, 'h00, 1);

        // R2: valid pointer but go clear holds the stream
        rw(RA_PTRL, 32'h0);
        rw(RA_PTRH, 32'h8000_0000);
        stall_check("R2 stalled without go");
        rw(RA_CTRL, 32'h1);

        send(20, 3, 0, "R4 R5 R6 normal frame");
        rr(RA_PTRL, r);
        chk_eq("R10 pointer advanced", r, 32'h20);
        send(12, 50, 1, "R6 error flag");
        send(5, 90, 0, "R7 short frame");
        send(17, 20, 0, "R8 truncated frame");

        // R9: unowned descriptor
        send(15, 7, 0, "R9 dropped frame");
        rr(RA_DROP, r);
        chk_eq("R9 drop count", r, 32'(m_drops));
        rr(RA_PTRL, r);
        chk_eq("R9 pointer kept", r, 32'h80);
        mem[4 * 8 + OFF_CS][B_OWN]     = 1'b1;
        exp_mem[4 * 8 + OFF_CS][B_OWN] = 1'b1;
        send(9, 33, 0, "R9 overrun marked");

        // R10: end of chain
        rr(RA_EOQ, r);
        chk_eq("R10 end of queue set", r, 32'h1);
        rr(RA_PTRH, r);
        chk_eq("R10 valid cleared", r, 32'h0);
        stall_check("R10 stalled at end of chain");

        // R11: write-one-to-clear and restart
        rw(RA_EOQ, 32'h0);
        rr(RA_EOQ, r);
        chk_eq("R11 zero write keeps flag", r, 32'h1);
        rw(RA_EOQ, 32'h1);
        rr(RA_EOQ, r);
        chk_eq("R11 one write clears flag", r, 32'h0);
        put_desc(0, 'h680, 64, 1, 'h20, 0);
        m_ptr = 0;
        rw(RA_PTRL, 32'h0);
        rw(RA_PTRH, 32'h8000_0000);
        send(9, 71, 0, "R11 restart frame");
        rr(RA_PTRL, r);
        chk_eq("R11 pointer after restart", r, 32'h20);
        rr(RA_EOQ, r);
        chk_eq("R11 flag stays clear", r, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule